// File: doc/BRIEF.md
# Fuse Controller Register Interface

This block is the register front end of a one-time-programmable fuse array. A 32-bit single-cycle register bus reaches a control register (plus set and clear aliases), a timing register that is passed to the programming engine, a data register, and a window of shadow registers that holds one copy of each fuse word. Software reads fuse contents from the shadows. Software refreshes the shadows by requesting a reload, which walks the whole array through a simple read port.

A fuse program operation is armed only by a control write that carries the unlock key together with the word address. The data write that follows then hands the address and data to an external programming engine and holds BUSY until the engine reports completion. Lock bits from the array guard programming. Captured lock bits guard the shadows. Any violation raises a sticky error flag. While that flag is set, every further shadow access, program and reload is refused, until software clears the flag.

Bus reads are registered: read data appears on `bus_rdata_o` one cycle after the request. Register offsets are 0x000 control, 0x004 set alias, 0x008 clear alias, 0x010 timing and 0x020 data. Shadow word n sits at 0x400 + 0x10*n.

Top module: `fuse_regif`

## Requirements
- R1: While reset is asserted, bus_rdata_o is 0. After reset is released, a shadow reload starts by itself on the first clock edge, so the first control read shows BUSY and RELOAD set, ERROR clear and address 0. When the reload finishes, every shadow holds its fuse word.
- R2: The control register layout is: word address in bits 7:0, BUSY in bit 8, ERROR in bit 9, RELOAD in bit 10. A write to 0x004 ORs bits 7:0 into the address. A write to 0x008 clears the address bits that are set in bits 7:0, and clears ERROR when bit 9 is set.
- R3: A program operation is armed only by a write to 0x000 whose bits 31:16 equal 0x3E77. Each arming allows exactly one program operation. A data write (0x020) that is not armed only updates the data register and raises no program request.
- R4: An armed data write to an unlocked, in-range word sets BUSY and pulses pgm_req_o with pgm_addr_o equal to the address and pgm_data_o equal to the data. BUSY stays set until pgm_done_i.
- R5: Address writes made during a program operation do not change pgm_addr_o.
- R6: Data register writes made while BUSY is set are ignored.
- R7: An armed data write to a write-locked word, or to an address of NWORDS or above, raises no program request and leaves BUSY clear. It sets ERROR.
- R8: A read of a shadow whose word is read-locked returns 0xBADABADA and sets ERROR.
- R9: While ERROR is set, shadow reads return 0, and shadow writes, program operations and reload requests have no effect. ERROR falls only through a clear-alias write with bit 9 set.
- R10: A shadow write made while a reload is running, or made to a write-locked word, sets ERROR and leaves the shadow unchanged. Otherwise the shadow takes the written value.
- R11: Writing bit 10 through 0x000 or 0x004 while idle copies every fuse word into its shadow over NWORDS cycles. BUSY and RELOAD stay set throughout and then both clear.
- R12: Shadow n reads at 0x400 + 0x10*n. The timing register at 0x010 reads back as written and drives timing_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read |
| timing_o | output | 32 | Timing register contents for the engine |
| pgm_req_o | output | 1 | One-cycle program request |
| pgm_addr_o | output | 8 | Captured word address of the program |
| pgm_data_o | output | 32 | Program data |
| pgm_done_i | input | 1 | Engine reports the program has finished |
| arr_addr_o | output | IDX_W | Fuse array read address |
| arr_rdata_i | input | 32 | Fuse word at arr_addr_o |
| arr_rlock_i | input | 1 | Read lock of the addressed word |
| arr_wlock_i | input | 1 | Write lock of the addressed word |

## Verification
The hardest case to create from the ports is a shadow write that lands inside the reload window. The bench requests a reload and issues the shadow write at the next bus slot, while the sweep is still running. It targets a word the sweep has already copied, so a write that slipped through would stay visible afterwards. A second hard case is the frozen program context. The bench makes the external engine slow on purpose, so that address and data writes can be issued while BUSY is still high, and then checks the engine-facing outputs.

// File: rtl/fuse_regif_pkg.sv
package fuse_regif_pkg;
  localparam logic [11:0] OFS_CTRL = 12'h000;
  localparam logic [11:0] OFS_SET  = 12'h004;
  localparam logic [11:0] OFS_CLR  = 12'h008;
  localparam logic [11:0] OFS_TIME = 12'h010;
  localparam logic [11:0] OFS_DATA = 12'h020;
  localparam int B_BUSY   = 8;
  localparam int B_ERR    = 9;
  localparam int B_RELOAD = 10;
  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam logic [31:0] RD_LOCKED  = 32'hBADA_BADA;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RELOAD, SEQ_PROG} seq_state_e;
endpackage

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_regif_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_start_i,
  input  logic             prog_start_i,
  input  logic [7:0]       prog_addr_i,
  input  logic             pgm_done_i,
  output logic             busy_o,
  output logic             reloading_o,
  output logic             programming_o,
  output logic [IDX_W-1:0] rl_idx_o,
  output logic             pgm_req_o,
  output logic [7:0]       pgm_addr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NWORDS - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SEQ_IDLE;
      cnt_q      <= '0;
      pgm_req_o  <= 1'b0;
      pgm_addr_o <= '0;
    end else begin
      pgm_req_o <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: begin
          if (reload_start_i) begin
            state_q <= SEQ_RELOAD;
            cnt_q   <= '0;
          end else if (prog_start_i) begin
            state_q    <= SEQ_PROG;
            pgm_addr_o <= prog_addr_i;   // private copy, immune to later address writes
            pgm_req_o  <= 1'b1;
          end
        end
        SEQ_RELOAD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) state_q <= SEQ_IDLE;
        end
        SEQ_PROG: if (pgm_done_i) state_q <= SEQ_IDLE;
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o        = (state_q != SEQ_IDLE);
  assign reloading_o   = (state_q == SEQ_RELOAD);
  assign programming_o = (state_q == SEQ_PROG);
  assign rl_idx_o      = cnt_q;

  // R5
  pgm_addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (programming_o && $past(programming_o)) |-> $stable(pgm_addr_o));
  // R11
  reload_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reloading_o) |-> ($past(rl_idx_o) == LAST));
  // R4
  prog_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (programming_o && !pgm_done_i) |=> programming_o);
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int NWORDS = 16,
  parameter int IDX_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rl_we_i,
  input  logic [IDX_W-1:0] rl_idx_i,
  input  logic [31:0]      rl_data_i,
  input  logic             rl_rlock_i,
  input  logic             rl_wlock_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             rlock_o,
  output logic             wlock_o
);
  logic [31:0] sh_vec [NWORDS];
  logic [NWORDS-1:0] rl_vec, wl_vec;

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic [31:0] sh_q;
    logic        rl_q, wl_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sh_q <= '0;
        rl_q <= 1'b0;
        wl_q <= 1'b0;
      end else if (rl_we_i && rl_idx_i == IDX_W'(g)) begin
        sh_q <= rl_data_i;
        rl_q <= rl_rlock_i;
        wl_q <= rl_wlock_i;
      end else if (wr_en_i && idx_i == IDX_W'(g)) begin
        sh_q <= wdata_i;
      end
    end
    assign sh_vec[g] = sh_q;
    assign rl_vec[g] = rl_q;
    assign wl_vec[g] = wl_q;
  end

  assign rdata_o = sh_vec[idx_i];
  assign rlock_o = rl_vec[idx_i];
  assign wlock_o = wl_vec[idx_i];

  // R10
  no_write_in_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rl_we_i));
endmodule

// File: rtl/fuse_regif.sv
module fuse_regif
  import fuse_regif_pkg::*;
#(
  parameter int NWORDS = 16,
  parameter int IDX_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [11:0]      bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic [31:0]      timing_o,
  output logic             pgm_req_o,
  output logic [7:0]       pgm_addr_o,
  output logic [31:0]      pgm_data_o,
  input  logic             pgm_done_i,
  output logic [IDX_W-1:0] arr_addr_o,
  input  logic [31:0]      arr_rdata_i,
  input  logic             arr_rlock_i,
  input  logic             arr_wlock_i
);
  logic [7:0]  addr_q;
  logic        unlock_q, error_q, boot_q;
  logic [31:0] data_q, timing_q;
  logic        busy, reloading, programming;
  logic [IDX_W-1:0] rl_idx, sh_idx;
  logic [31:0] sh_rdata;
  logic        sh_rlock, sh_wlock;

  wire wr     = bus_req_i &  bus_we_i;
  wire rd     = bus_req_i & !bus_we_i;
  wire is_sh  = (bus_addr_i[11:10] == 2'b01) && (bus_addr_i[3:0] == 4'h0)
                && (int'(bus_addr_i[9:4]) < NWORDS);
  wire wr_ctrl = wr && bus_addr_i == OFS_CTRL;
  wire wr_set  = wr && bus_addr_i == OFS_SET;
  wire wr_clr  = wr && bus_addr_i == OFS_CLR;
  wire wr_data = wr && bus_addr_i == OFS_DATA && !busy;
  wire wr_sh   = wr && is_sh;
  wire rd_sh   = rd && is_sh;
  assign sh_idx = bus_addr_i[4 +: IDX_W];

  wire prog_locked  = arr_wlock_i || (int'(addr_q) >= NWORDS);
  wire reload_start = (boot_q || ((wr_ctrl || wr_set) && bus_wdata_i[B_RELOAD]))
                      && !busy && !error_q;
  wire prog_try     = wr_data && unlock_q && !error_q && !reload_start;
  wire prog_start   = prog_try && !prog_locked;
  wire sh_wr_ok     = wr_sh && !error_q && !reloading && !sh_wlock;
  wire err_set      = (prog_try && prog_locked)
                    || (wr_sh && !error_q && (reloading || sh_wlock))
                    || (rd_sh && !error_q && sh_rlock);

  assign arr_addr_o = reloading ? rl_idx : addr_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      unlock_q <= 1'b0;
      error_q  <= 1'b0;
      boot_q   <= 1'b1;
      data_q   <= '0;
      timing_q <= '0;
    end else begin
      boot_q <= 1'b0;
      if (wr_ctrl) begin
        addr_q   <= bus_wdata_i[7:0];
        unlock_q <= (bus_wdata_i[31:16] == UNLOCK_KEY);
      end
      if (wr_set) addr_q <= addr_q | bus_wdata_i[7:0];
      if (wr_clr) addr_q <= addr_q & ~bus_wdata_i[7:0];
      if (wr && bus_addr_i == OFS_TIME) timing_q <= bus_wdata_i;
      if (wr_data) begin
        data_q <= bus_wdata_i;
        if (unlock_q) unlock_q <= 1'b0;
      end
      if (err_set) error_q <= 1'b1;
      else if (wr_clr && bus_wdata_i[B_ERR]) error_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else if (rd) begin
      if (is_sh)
        bus_rdata_o <= error_q ? 32'h0 : (sh_rlock ? RD_LOCKED : sh_rdata);
      else unique case (bus_addr_i)
        OFS_CTRL, OFS_SET, OFS_CLR:
                  bus_rdata_o <= {21'h0, reloading, error_q, busy, addr_q};
        OFS_TIME: bus_rdata_o <= timing_q;
        OFS_DATA: bus_rdata_o <= data_q;
        default:  bus_rdata_o <= '0;
      endcase
    end
  end

  assign timing_o   = timing_q;
  assign pgm_data_o = data_q;

  fuse_seq #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_seq (
    .clk_i, .rst_ni,
    .reload_start_i (reload_start),
    .prog_start_i   (prog_start),
    .prog_addr_i    (addr_q),
    .pgm_done_i,
    .busy_o         (busy),
    .reloading_o    (reloading),
    .programming_o  (programming),
    .rl_idx_o       (rl_idx),
    .pgm_req_o,
    .pgm_addr_o
  );

  fuse_shadow_bank #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_bank (
    .clk_i, .rst_ni,
    .rl_we_i    (reloading),
    .rl_idx_i   (rl_idx),
    .rl_data_i  (arr_rdata_i),
    .rl_rlock_i (arr_rlock_i),
    .rl_wlock_i (arr_wlock_i),
    .wr_en_i    (sh_wr_ok),
    .idx_i      (sh_idx),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (sh_rdata),
    .rlock_o    (sh_rlock),
    .wlock_o    (sh_wlock)
  );

  // R3
  unlock_consumed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_o |-> !unlock_q);
  // R6
  data_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (programming && $past(programming)) |-> $stable(data_q));
  // R9
  err_clear_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(error_q) |-> $past(wr_clr && bus_wdata_i[B_ERR]));
  // R7
  lock_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_req_o |-> $past(!arr_wlock_i));
endmodule

// File: tb/sim_fuse_regif.sv
module sim_fuse_regif;
  localparam int NW = 16;
  localparam int IW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, timing, pgm_data;
  logic        pgm_req, pgm_done = 1'b0;
  logic [7:0]  pgm_addr;
  logic [IW-1:0] arr_addr;
  logic [31:0] fuse_mem [NW];
  logic [NW-1:0] fuse_rl, fuse_wl;
  int checks = 0, errors = 0, pgm_seen = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fuse_regif #(.NWORDS(NW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .timing_o(timing), .pgm_req_o(pgm_req), .pgm_addr_o(pgm_addr),
    .pgm_data_o(pgm_data), .pgm_done_i(pgm_done), .arr_addr_o(arr_addr),
    .arr_rdata_i(fuse_mem[arr_addr]), .arr_rlock_i(fuse_rl[arr_addr]),
    .arr_wlock_i(fuse_wl[arr_addr])
  );

  // slow programming engine model
  initial begin
    forever begin
      @(negedge clk);
      if (pgm_req) begin
        pgm_seen++;
        repeat (10) @(negedge clk);
        fuse_mem[pgm_addr[IW-1:0]] = fuse_mem[pgm_addr[IW-1:0]] | pgm_data;
        pgm_done = 1'b1;
        @(negedge clk);
        pgm_done = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] c;
    for (int k = 0; k < 200; k++) begin
      rd32(12'h000, c);
      if (!c[8]) break;
    end
  endtask

  function automatic logic [11:0] sh(input int n);
    return 12'(12'h400 + 16 * n);
  endfunction

  // {we, addr, wdata, expected}
  localparam logic [76:0] VEC [10] = '{
    {1'b1, 12'h010, 32'h1234_5678, 32'h0},
    {1'b0, 12'h010, 32'h0,         32'h1234_5678},
    {1'b1, 12'h020, 32'h0000_CAFE, 32'h0},
    {1'b0, 12'h020, 32'h0,         32'h0000_CAFE},
    {1'b1, 12'h000, 32'h0000_0012, 32'h0},
    {1'b0, 12'h000, 32'h0,         32'h0000_0012},
    {1'b1, 12'h004, 32'h0000_0021, 32'h0},
    {1'b0, 12'h000, 32'h0,         32'h0000_0033},
    {1'b1, 12'h008, 32'h0000_0003, 32'h0},
    {1'b0, 12'h000, 32'h0,         32'h0000_0030}
  };

  initial begin
    logic [31:0] r;
    for (int n = 0; n < NW; n++) fuse_mem[n] = 32'hA500_0000 | 32'(n * 32'h111);
    fuse_rl = '0; fuse_wl = '0;
    fuse_rl[5] = 1'b1;
    fuse_wl[3] = 1'b1;

    #15 chk("R1 rdata in reset", rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk);
    rd32(12'h000, r);
    chk("R1 boot reload ctrl", r, 32'h0000_0500);
    wait_idle();
    rd32(sh(2), r);  chk("R1 R12 shadow2 after boot", r, fuse_mem[2]);
    rd32(sh(15), r); chk("R1 R12 shadow15 after boot", r, fuse_mem[15]);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][76]) wr32(VEC[i][75:64], VEC[i][63:32]);
      else begin
        rd32(VEC[i][75:64], r);
        chk(i < 4 ? "R12 table readback" : "R2 table ctrl", r, VEC[i][31:0]);
      end
    end
    chk("R3 plain data write no program", 32'(pgm_seen), 32'd0);
    chk("R12 timing_o", timing, 32'h1234_5678);

    // armed program of word 2, engine held busy long enough to poke
    wr32(12'h000, {16'h3E77, 16'h0002});
    wr32(12'h020, 32'h0000_00F0);
    rd32(12'h000, r);
    chk("R4 busy during program", r & 32'h0000_0700, 32'h0000_0100);
    chk("R4 pgm_data", pgm_data, 32'h0000_00F0);
    wr32(12'h000, 32'h0000_0007);
    chk("R5 pgm_addr held", {24'h0, pgm_addr}, 32'h2);
    wr32(12'h020, 32'h0000_FFFF);
    rd32(12'h020, r);
    chk("R6 data frozen", r, 32'h0000_00F0);
    wait_idle();
    chk("R4 one request", 32'(pgm_seen), 32'd1);

    wr32(12'h004, 32'h0000_0400);
    rd32(12'h000, r);
    chk("R11 reload flags", r & 32'h0000_0700, 32'h0000_0500);
    wait_idle();
    rd32(12'h000, r);
    chk("R11 flags clear", r & 32'h0000_0700, 32'h0);
    rd32(sh(2), r);
    chk("R11 shadow2 reloaded", r, 32'hA500_02F2);

    wr32(12'h020, 32'h0000_0001);
    chk("R3 unlock used up", 32'(pgm_seen), 32'd1);

    wr32(12'h000, {16'h3E77, 16'h0003});
    wr32(12'h020, 32'h0000_0001);
    rd32(12'h000, r);
    chk("R7 locked word", r, 32'h0000_0203);
    chk("R7 no request", 32'(pgm_seen), 32'd1);

    wr32(sh(2), 32'hDEAD_0000);
    rd32(sh(2), r);
    chk("R9 read refused", r, 32'h0);
    wr32(12'h004, 32'h0000_0400);
    rd32(12'h000, r);
    chk("R9 reload refused", r, 32'h0000_0203);
    wr32(12'h000, 32'h0000_0200);
    rd32(12'h000, r);
    chk("R9 ctrl write keeps error", r, 32'h0000_0200);
    wr32(12'h008, 32'h0000_0200);
    rd32(12'h000, r);
    chk("R9 R2 clear alias", r, 32'h0);
    rd32(sh(2), r);
    chk("R9 write refused", r, 32'hA500_02F2);

    rd32(sh(5), r);
    chk("R8 locked read value", r, 32'hBADA_BADA);
    rd32(12'h000, r);
    chk("R8 error set", r & 32'h200, 32'h200);
    wr32(12'h008, 32'h0000_0200);

    wr32(sh(4), 32'h0000_1111);
    rd32(sh(4), r);
    chk("R10 shadow write", r, 32'h0000_1111);
    wr32(sh(3), 32'h0000_2222);
    rd32(12'h000, r);
    chk("R10 locked shadow write error", r & 32'h200, 32'h200);
    wr32(12'h008, 32'h0000_0200);
    rd32(sh(3), r);
    chk("R10 locked shadow unchanged", r, fuse_mem[3]);

    wr32(12'h004, 32'h0000_0400);
    wr32(sh(0), 32'h0000_5555);
    wait_idle();
    rd32(12'h000, r);
    chk("R10 write during reload error", r & 32'h200, 32'h200);
    wr32(12'h008, 32'h0000_0200);
    rd32(sh(0), r);
    chk("R10 shadow0 unchanged", r, fuse_mem[0]);
    rd32(sh(4), r);
    chk("R11 shadow4 restored", r, fuse_mem[4]);

    wr32(12'h000, {16'h3E77, 16'h0020});
    wr32(12'h020, 32'h0000_0001);
    rd32(12'h000, r);
    chk("R7 out of range", r, 32'h0000_0220);
    chk("R7 no request range", 32'(pgm_seen), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule